// File: doc/BRIEF.md
# Handshaked Retention Register Bank

This block holds a small set of retention registers behind a slow write path that signals when it is busy. A bus-side port writes one register by index and reads any register by index. A write that the block accepts is held and committed to storage only after a fixed number of cycles. While the commit is in progress, the `ready` output is low and the block ignores any further write.

The block raises an interrupt status when `ready` goes back high. Software clears this status by writing one to it, and an enable bit controls whether the status drives the `irq` output. The storage array has no reset. This models registers that keep their contents when the rest of the logic is reset. Only the handshake and the interrupt state return to idle on `rstN`.

Top module: `bkupRegBank`

## Requirements
- R1: The bank holds NUM_REGS (default 4) registers of DATA_W (default 32) bits, selected by index 0 to NUM_REGS-1. `rdData` shows the committed contents of register `rdIdx` combinationally at any time, including while a commit is pending. A register keeps its old value until its own commit lands.
- R2: A write is accepted when `wrEn` is high on a clock edge while `ready` is 1. In the cycle after that edge, `ready` is 0. `ready` stays 0 for exactly COMMIT_CYCLES cycles (default 4) and then returns to 1. The new value is visible on `rdData` from the same cycle in which `ready` returns to 1.
- R3: A write presented while `ready` is 0 is discarded. It changes no register, it does not lengthen the current busy window, and it is not replayed later.
- R4: `rstN` low does not change the stored register contents. Reset sets `ready` to 1, `irqStatus` to 0 and the interrupt enable to 0, and abandons any write still being committed.
- R5: Each 0-to-1 transition of `ready` sets `irqStatus` to 1. It sets it in the same cycle that `ready` rises.
- R6: `irqStatus` stays 1 until a `ctlWr` with `ctlClr`=1 clears it. If the clear and a new rise of `ready` happen on the same edge, the status stays 1.
- R7: `irq` equals `irqStatus` AND the interrupt enable. The enable takes the value of `ctlIrqEn` on every `ctlWr`, and `irq` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low bus reset (storage not affected) |
| wrEn | input | 1 | Write request |
| wrIdx | input | IDX_W | Register index of the write |
| wrData | input | DATA_W | Write data |
| rdIdx | input | IDX_W | Register index to read |
| rdData | output | DATA_W | Committed contents of register rdIdx |
| ready | output | 1 | High when a new write will be accepted |
| ctlWr | input | 1 | Control write strobe |
| ctlIrqEn | input | 1 | New interrupt enable value on ctlWr |
| ctlClr | input | 1 | On ctlWr, 1 clears irqStatus |
| irqStatus | output | 1 | Sticky ready-rise status |
| irq | output | 1 | Interrupt request (status gated by enable) |

## Verification
The two events that can meet on one edge are the commit that raises `ready` and sets the status, and a software clear of that same status. The bench schedules the clear so that it lands exactly on the edge where the commit completes. It then expects `irqStatus` to stay 1 in the next cycle. A second overlap is a write attempted while a commit is in flight. The bench checks that this write is not taken. It confirms this by checking that `ready` rises on its original schedule and that neither register touched by the dropped write changes.

// File: rtl/bkupPkg.sv
package bkupPkg;
  // Strobes passed from the control side to the datapath
  typedef struct packed {
    logic capture;  // latch the incoming write into the pending slot
    logic commit;   // move the pending slot into the selected register
  } bkupStrb_t;
endpackage

// File: rtl/bkupCtl.sv
module bkupCtl
  import bkupPkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      ctlWr,
  input  logic      ctlIrqEn,
  input  logic      ctlClr,
  output bkupStrb_t strb,
  output logic      ready,
  output logic      irqStatus,
  output logic      irq
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             irqEn;

  assign ready       = !busy;
  assign strb.capture = wrEn && !busy;
  assign strb.commit  = busy && (cnt == '0);
  assign irq          = irqStatus && irqEn;

  // Commit window: loads on an accepted write, then counts down to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.capture) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  // Sticky status: the commit sets it and wins over a clear on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStatus <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (strb.commit)          irqStatus <= 1'b1;
      else if (ctlWr && ctlClr) irqStatus <= 1'b0;
      if (ctlWr)                irqEn     <= ctlIrqEn;
    end
  end

  // R2: an accepted write pulls ready low in the following cycle
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ready) |=> !ready);

  // R2: ready stays low while the countdown has not reached zero
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && cnt != '0) |=> !ready);

  // R3: a write during the busy window never reloads the countdown
  a_r3_no_extend: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R5: the status is already set in the cycle where ready rises
  a_r5_set_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> irqStatus);

  // R6: without a clear request the status holds
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus && !(ctlWr && ctlClr)) |=> irqStatus);
endmodule

// File: rtl/bkupDp.sv
module bkupDp
  import bkupPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  bkupStrb_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  logic [IDX_W-1:0]  pendIdx;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] bank [NUM_REGS];

  // Pending slot: no reset needed, only meaningful while a commit is open
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      pendIdx  <= wrIdx;
      pendData <= wrData;
    end
  end

  // Retention storage: deliberately outside the bus reset
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (strb.commit && pendIdx == IDX_W'(i)) bank[i] <= pendData;
    end
  end

  assign rdData = bank[rdIdx];
endmodule

// File: rtl/bkupRegBank.sv
module bkupRegBank
  import bkupPkg::*;
#(
  parameter int NUM_REGS      = 4,
  parameter int DATA_W        = 32,
  parameter int COMMIT_CYCLES = 4,
  localparam int IDX_W        = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  input  logic              ctlWr,
  input  logic              ctlIrqEn,
  input  logic              ctlClr,
  output logic              irqStatus,
  output logic              irq
);
  bkupStrb_t strb;

  bkupCtl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .ctlWr(ctlWr), .ctlIrqEn(ctlIrqEn), .ctlClr(ctlClr),
    .strb(strb), .ready(ready), .irqStatus(irqStatus), .irq(irq)
  );

  bkupDp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  // R7: the request line is never up without the status behind it
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqStatus);
endmodule

// File: tb/bkupRegBank_tb.sv
module bkupRegBank_tb;
  localparam int LAT = 4;
  localparam int NV  = 6;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 32'hDEAD_BEEF}, {2'd1, 32'h1234_5678}, {2'd2, 32'h0000_0001},
    {2'd3, 32'hFFFF_FFFF}, {2'd1, 32'hA5A5_5A5A}, {2'd0, 32'h0F0F_0F0F}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, ctlWr = 1'b0, ctlIrqEn = 1'b0, ctlClr = 1'b0;
  logic [1:0]  wrIdx = '0, rdIdx = '0;
  logic [31:0] wrData = '0, rdData;
  logic        ready, irqStatus, irq;
  logic [31:0] model [4];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  bkupRegBank #(.NUM_REGS(4), .DATA_W(32), .COMMIT_CYCLES(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .ready(ready), .ctlWr(ctlWr),
    .ctlIrqEn(ctlIrqEn), .ctlClr(ctlClr), .irqStatus(irqStatus), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one write; returns at the first negedge after the accepting edge
  task automatic pulseWrite(logic [1:0] idx, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ctlOp(logic en, logic clr);
    @(negedge clk); ctlWr = 1'b1; ctlIrqEn = en; ctlClr = clr;
    @(negedge clk); ctlWr = 1'b0; ctlClr = 1'b0;
  endtask

  task automatic checkAll(string tag);
    for (int r = 0; r < 4; r++) begin
      rdIdx = 2'(r); #0.1;
      check(tag, rdData, model[r]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 reset ready", 32'(ready), 32'd1);
    check("R4 reset status", 32'(irqStatus), 32'd0);
    check("R4 reset irq", 32'(irq), 32'd0);

    // Initialise all registers so the model is known
    for (int r = 0; r < 4; r++) begin
      pulseWrite(2'(r), 32'h1000 + 32'(r));
      model[r] = 32'h1000 + 32'(r);
      repeat (LAT) @(negedge clk);
    end
    checkAll("R1 init readback");

    // Vector walk: timing of ready, old value held, new value on rise
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  idx;
      logic [31:0] d;
      idx = VEC[v][33:32]; d = VEC[v][31:0];
      rdIdx = idx;
      pulseWrite(idx, d);
      check("R2 ready low after accept", 32'(ready), 32'd0);
      check("R1 old value while pending", rdData, model[idx]);
      repeat (LAT - 1) @(negedge clk);
      check("R2 ready low at last busy cycle", 32'(ready), 32'd0);
      @(negedge clk);
      model[idx] = d;
      check("R2 ready back high", 32'(ready), 32'd1);
      check("R2 new value visible", rdData, d);
      check("R5 status set on rise", 32'(irqStatus), 32'd1);
      ctlOp(1'b0, 1'b1);
      check("R6 status cleared", 32'(irqStatus), 32'd0);
    end
    checkAll("R1 bank after vectors");

    // R3: writes during the busy window are dropped, window not extended
    pulseWrite(2'd0, 32'hAAAA_0000);
    wrEn = 1'b1; wrIdx = 2'd1; wrData = 32'hBBBB_1111;
    @(negedge clk);
    wrIdx = 2'd0; wrData = 32'hCCCC_2222;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (LAT - 3) @(negedge clk);
    check("R3 ready still low on schedule", 32'(ready), 32'd0);
    @(negedge clk);
    check("R3 ready rises on original schedule", 32'(ready), 32'd1);
    model[0] = 32'hAAAA_0000;
    repeat (LAT + 2) @(negedge clk);
    check("R3 no replayed write", 32'(ready), 32'd1);
    checkAll("R3 dropped writes left no trace");

    // R7: enable gating
    check("R7 irq masked", 32'(irq), 32'd0);
    ctlOp(1'b1, 1'b0);
    check("R7 irq after enable", 32'(irq), 32'd1);
    ctlOp(1'b1, 1'b1);
    check("R7 irq after clear", 32'(irq), 32'd0);

    // R6: clear on the same edge as the commit — set wins
    pulseWrite(2'd2, 32'h5555_6666);
    repeat (LAT - 1) @(negedge clk);
    ctlWr = 1'b1; ctlIrqEn = 1'b1; ctlClr = 1'b1;
    @(negedge clk);
    ctlWr = 1'b0; ctlClr = 1'b0;
    model[2] = 32'h5555_6666;
    check("R6 set wins over clear", 32'(irqStatus), 32'd1);
    check("R7 irq with enable", 32'(irq), 32'd1);

    // R4: reset leaves storage, clears handshake and interrupt state
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R4 status cleared by reset", 32'(irqStatus), 32'd0);
    check("R4 enable cleared by reset", 32'(irq), 32'd0);
    checkAll("R4 contents kept through reset");

    // R4: reset during a pending commit abandons it
    pulseWrite(2'd3, 32'h7777_8888);
    rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R4 ready after reset mid-commit", 32'(ready), 32'd1);
    repeat (LAT + 1) @(negedge clk);
    checkAll("R4 pending write abandoned");
    check("R4 no status from abandoned write", 32'(irqStatus), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule